// File: doc/BRIEF.md
# Parallel printer port controller

This block is a register-mapped parallel printer port for a byte-wide host bus. It keeps an outgoing data latch, an incoming data latch, a status register and a control register, and it carries a small model of the printer on the far side of the cable. Software prints a character by writing the data register and then toggling the strobe bit in the control register. The block turns a rising strobe into one byte on a valid/ready output stream.

The printer's busy and acknowledge lines are not timed. Each status read moves the handshake one step forward, so a driver that polls status sees the usual not-busy, acknowledge and idle sequence. An interrupt becomes pending when strobe is released with interrupts enabled, and a status read clears it. While the direction bit selects input, the incoming latch follows an external 8-bit input port on every clock.

Bus reads are registered: read data appears one clock after the read strobe. When read and write are asserted in the same cycle, the read is ignored.

Top module: `lpt_port_ctrl`

## Requirements
- R1: After reset the data register reads 0xFF, status reads 0xD9, control reads 0xCC, and `irq`, `out_valid` and `overflow` are all 0.
- R2: Offset 0 selects data, offset 1 selects status and offset 2 selects control. Reads of offsets 3 to 7 return 0xFF. Writes to status and to offsets 3 to 7 change nothing that can be read back.
- R3: A control write stores the written value with bits 7:6 forced to 1. A control read returns the stored value.
- R4: A control write with init (bit 2) = 0 loads status with 0xD8 (bit 0 cleared) and emits no byte.
- R5: A control write with init = 1, select-in (bit 3) = 1 and strobe (bit 0) = 1 clears status bit 7. If strobe was 0 in the previous control value, the data-out byte appears on `out_data` with `out_valid` high one clock after the write.
- R6: A control write with init = 1, select-in = 1 and strobe = 0, where the previous control value has interrupt enable (bit 4) = 1, raises `irq` one clock after the write.
- R7: A status read returns the status held before the read and drops `irq`. If status bit 7 = 0 and control strobe = 0 at that read, the handshake advances: if bit 6 (acknowledge) = 1 it is cleared; otherwise bits 7 and 6 are both set.
- R8: With direction (control bit 5) = 1, the input latch samples `pin_in` on every clock and a data read returns it. With direction = 0, a data read returns the last byte written to data.
- R9: `out_valid` and `out_data` hold until `out_ready` is seen. A new byte emitted in the same cycle that the held byte is accepted replaces it.
- R10: A byte emitted while the previous byte is held and not accepted in that cycle is dropped, and `overflow` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; ignored during a write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after `bus_rd` |
| pin_in | input | 8 | External input byte, sampled while direction = 1 |
| out_data | output | 8 | Emitted byte |
| out_valid | output | 1 | Emitted byte is held |
| out_ready | input | 1 | Consumer accepts the held byte |
| irq | output | 1 | Interrupt level, equal to the pending flag |
| overflow | output | 1 | Sticky flag: a byte was dropped |

## Verification
Two functions can meet in the same cycle: the consumer accepting the held byte, and a strobe edge emitting the next byte. The bench raises `out_ready` during the control write that makes the new strobe edge. It then checks that the second byte replaced the first rather than being dropped. In a separate case it holds `out_ready` low across a second strobe edge and checks that the first byte stays on the stream and that `overflow` is set.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int OFF_W  = 3;
  localparam int BYTE_W = 8;

  localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STS  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;

  // status bit positions
  localparam int S_NBUSY = 7;
  localparam int S_ACK   = 6;
  localparam int S_TMO   = 0;

  // control bit positions
  localparam int C_DIR  = 5;
  localparam int C_IEN  = 4;
  localparam int C_SEL  = 3;
  localparam int C_INIT = 2;
  localparam int C_STB  = 0;

  localparam logic [BYTE_W-1:0] CTRL_FORCE  = 8'hC0;
  localparam logic [BYTE_W-1:0] STS_RESET   = 8'hD9;
  localparam logic [BYTE_W-1:0] STS_INITLD  = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RESET  = 8'hCC;
  localparam logic [BYTE_W-1:0] DATA_RESET  = 8'hFF;
  localparam logic [BYTE_W-1:0] UNMAPPED_RD = 8'hFF;
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFF_W-1:0] off,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     dataw_q,
  output logic [W-1:0]     datar_q,
  output logic [W-1:0]     status_q,
  output logic [W-1:0]     ctrl_q,
  output logic             pend_q,
  output logic             emit
);
  logic [W-1:0] ctrl_nxt;
  logic         wr_ctrl;
  logic         rd_sts;
  logic         hs_step;

  assign ctrl_nxt = wdata | CTRL_FORCE;
  assign wr_ctrl  = wr_en && (off == OFF_CTRL);
  assign rd_sts   = rd_en && (off == OFF_STS);
  assign hs_step  = !status_q[S_NBUSY] && !ctrl_q[C_STB];
  assign emit     = wr_ctrl && ctrl_nxt[C_INIT] && ctrl_nxt[C_SEL] &&
                    ctrl_nxt[C_STB] && !ctrl_q[C_STB];

  always_ff @(posedge clk) begin
    if (rst) begin
      dataw_q  <= DATA_RESET;
      datar_q  <= DATA_RESET;
      status_q <= STS_RESET;
      ctrl_q   <= CTRL_RESET;
      pend_q   <= 1'b0;
    end else begin
      if (ctrl_q[C_DIR]) datar_q <= pin_in;
      if (wr_en) begin
        if (off == OFF_DATA) dataw_q <= wdata;
        if (wr_ctrl) begin
          ctrl_q <= ctrl_nxt;
          if (!ctrl_nxt[C_INIT]) begin
            status_q <= STS_INITLD;
          end else if (ctrl_nxt[C_SEL]) begin
            if (ctrl_nxt[C_STB]) status_q[S_NBUSY] <= 1'b0;
            else if (ctrl_q[C_IEN]) pend_q <= 1'b1;
          end
        end
      end else if (rd_sts) begin
        pend_q <= 1'b0;
        if (hs_step) begin
          if (status_q[S_ACK]) begin
            status_q[S_ACK] <= 1'b0;
          end else begin
            status_q[S_ACK]   <= 1'b1;
            status_q[S_NBUSY] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lpt_rd_mux.sv
module lpt_rd_mux
  import lpt_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [OFF_W-1:0] off,
  input  logic [W-1:0]     dataw,
  input  logic [W-1:0]     datar,
  input  logic [W-1:0]     status,
  input  logic [W-1:0]     ctrl,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] sel;

  always_comb begin
    case (off)
      OFF_DATA: sel = ctrl[C_DIR] ? datar : dataw;
      OFF_STS:  sel = status;
      OFF_CTRL: sel = ctrl;
      default:  sel = UNMAPPED_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= UNMAPPED_RD;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/lpt_out_stream.sv
module lpt_out_stream #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         emit,
  input  logic [W-1:0] byte_in,
  input  logic         ready,
  output logic [W-1:0] data,
  output logic         valid,
  output logic         ovf
);
  logic take;
  assign take = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      valid <= 1'b0;
      ovf   <= 1'b0;
    end else if (emit) begin
      if (valid && !take) begin
        ovf <= 1'b1;
      end else begin
        data  <= byte_in;
        valid <= 1'b1;
      end
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lpt_port_ctrl.sv
module lpt_port_ctrl
  import lpt_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             irq,
  output logic             overflow
);
  logic         rd_en;
  logic [W-1:0] dataw_q, datar_q, status_q, ctrl_q;
  logic         pend_q;
  logic         emit;

  assign rd_en = bus_rd && !bus_wr;
  assign irq   = pend_q;

  lpt_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(rd_en), .off(bus_addr),
    .wdata(bus_wdata), .pin_in(pin_in), .dataw_q(dataw_q), .datar_q(datar_q),
    .status_q(status_q), .ctrl_q(ctrl_q), .pend_q(pend_q), .emit(emit)
  );

  lpt_rd_mux #(.W(W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .off(bus_addr), .dataw(dataw_q),
    .datar(datar_q), .status(status_q), .ctrl(ctrl_q), .rdata(bus_rdata)
  );

  lpt_out_stream #(.W(W)) u_out (
    .clk(clk), .rst(rst), .emit(emit), .byte_in(dataw_q), .ready(out_ready),
    .data(out_data), .valid(out_valid), .ovf(overflow)
  );
endmodule

// File: rtl/lpt_port_ctrl_chk.sv
module lpt_port_ctrl_chk
  import lpt_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input logic             clk,
  input logic             rst,
  input logic [OFF_W-1:0] bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [W-1:0]     bus_wdata,
  input logic [W-1:0]     bus_rdata,
  input logic [W-1:0]     out_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic             irq,
  input logic             overflow
);
  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr > OFF_CTRL) |=> bus_rdata == UNMAPPED_RD); // R2
  AST_CTRL_TOP_ONES: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == OFF_CTRL) |=> bus_rdata[7:6] == 2'b11); // R3
  AST_INIT_NO_EMIT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_CTRL && !bus_wdata[C_INIT]) |=> !$rose(out_valid)); // R4
  AST_STS_READ_CLR_IRQ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == OFF_STS) |=> !irq); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R10
endmodule

bind lpt_port_ctrl lpt_port_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .irq(irq), .overflow(overflow)
);

// File: tb/lpt_port_ctrl_tb.sv
module lpt_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] out_data;
  logic       out_valid, out_ready = 1'b0, irq, overflow;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lpt_port_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .irq(irq), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 out_valid", {7'd0, out_valid}, 8'h00);
    chk("R1 overflow", {7'd0, overflow}, 8'h00);
    rd(3'd0, v); chk("R1 data", v, 8'hFF);
    rd(3'd1, v); chk("R1 status", v, 8'hD9);
    rd(3'd2, v); chk("R1 control", v, 8'hCC);
    rd(3'd5, v); chk("R2 unmapped read", v, 8'hFF);
  endtask

  task automatic t_print_handshake;
    logic [7:0] v;
    wr(3'd0, 8'h41);
    wr(3'd2, 8'h0D);
    chk("R5 out_valid", {7'd0, out_valid}, 8'h01);
    chk("R5 out_data", out_data, 8'h41);
    rd(3'd2, v); chk("R3 control readback", v, 8'hCD);
    repeat (3) @(negedge clk);
    chk("R9 hold valid", {7'd0, out_valid}, 8'h01);
    rd(3'd1, v); chk("R5 busy cleared", v, 8'h59);
    wr(3'd2, 8'h1C);
    chk("R6 no irq without prior enable", {7'd0, irq}, 8'h00);
    rd(3'd1, v); chk("R7 step0", v, 8'h59);
    rd(3'd1, v); chk("R7 ack cleared", v, 8'h19);
    rd(3'd1, v); chk("R7 busy ack set", v, 8'hD9);
  endtask

  task automatic t_overflow_irq;
    logic [7:0] v;
    wr(3'd0, 8'h42);
    wr(3'd2, 8'h1D);
    chk("R10 overflow set", {7'd0, overflow}, 8'h01);
    chk("R10 held byte kept", out_data, 8'h41);
    wr(3'd2, 8'h1C);
    chk("R6 irq raised", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R7 status value", v, 8'h59);
    chk("R7 irq cleared", {7'd0, irq}, 8'h00);
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    chk("R9 accepted", {7'd0, out_valid}, 8'h00);
    chk("R10 overflow sticky", {7'd0, overflow}, 8'h01);
  endtask

  task automatic t_accept_and_emit;
    wr(3'd0, 8'h55);
    wr(3'd2, 8'h1D);
    chk("R5 second byte", out_data, 8'h55);
    wr(3'd0, 8'h66);
    wr(3'd2, 8'h1C);
    @(negedge clk);
    bus_addr = 3'd2; bus_wdata = 8'h1D; bus_wr = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; out_ready = 1'b0;
    chk("R9 replaced valid", {7'd0, out_valid}, 8'h01);
    chk("R9 replaced data", out_data, 8'h66);
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic t_init_and_dir;
    logic [7:0] v;
    wr(3'd2, 8'h08);
    chk("R4 no emit", {7'd0, out_valid}, 8'h00);
    rd(3'd1, v); chk("R4 status reload", v, 8'hD8);
    rd(3'd2, v); chk("R3 forced top bits", v, 8'hC8);
    pin_in = 8'hA5;
    wr(3'd2, 8'h2C);
    @(negedge clk);
    rd(3'd0, v); chk("R8 input latch", v, 8'hA5);
    pin_in = 8'h3C;
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R8 input follows pin", v, 8'h3C);
    wr(3'd2, 8'h0C);
    rd(3'd0, v); chk("R8 output latch", v, 8'h66);
    wr(3'd1, 8'h00);
    wr(3'd6, 8'h00);
    rd(3'd1, v); chk("R2 status write ignored", v, 8'hD8);
    rd(3'd0, v); chk("R2 unmapped write ignored", v, 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_print_handshake();
    t_overflow_irq();
    t_accept_and_emit();
    t_init_and_dir();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule